// File: doc/BRIEF.md
# Card Command Sequencer with Interrupt Routing

This block is the control and command-issue part of a memory-card host controller. A processor programs it through a small register port. The registers hold a six-bit command index, a 32-bit argument written as two 16-bit halves, a command configuration word, several transfer setup values, an interrupt mask, and the card clock start and stop control. A command leaves the block as a one-cycle `cmd_start` pulse that carries the index and argument. It can only leave when the card clock is enabled and a command is pending.

The card-side logic answers each command with a byte count and then that many bytes. The sequencer packs the bytes in pairs into a nine-entry halfword response queue that software drains one entry per read. It then compares the byte count with the minimum the configured response type needs. If the count meets the minimum, it sets a completion status bit. If it falls short, it sets a timeout status bit.

A single interrupt line is the OR of the unmasked request bits. When DMA is enabled in the configuration word, the receive and transmit FIFO request bits are taken out of the interrupt and drive two DMA request outputs instead.

Top module: `card_cmd_seq`

## Requirements
- R1: A write to address 3 (configuration) stores the data ANDed with 0x3DFF, marks a command as pending and clears `xfer_active`. If data bit 10 (hold) is clear and the clock is enabled, `cmd_start` is high in the cycle after the write; otherwise no command leaves.
- R2: A write to address 0 with bit 1 set and bit 0 clear sets status bit 8 (clock on) and clears request bit 4 (clock off); a pending command whose stored hold bit is clear then issues. A write with bit 0 set clears status bit 8, sets request bit 4, clears `xfer_active` and abandons any wait for a response.
- R3: Configuration bits [1:0] select the minimum response length: 0 needs 0 bytes, 1 and 3 need 4 bytes, 2 needs 16 bytes. A count at or above the minimum sets status bit 13; a shorter count sets status bit 1. Issuing a command clears both bits. Status is read at address 1.
- R4: Every issued command sets request bit 2. Writing 1 to bit 2 at address 9 clears it. Request bits are read at address 9.
- R5: Response byte 2k goes to the low byte and byte 2k+1 to the high byte of queue entry k (k = 0..8). Bytes past the eighteenth are dropped. Each read of address 13 returns the next entry and then advances. After a successful completion, all reads from the tenth on return zero, and after a timeout or before any completion every read returns zero.
- R6: `irq` is high exactly when some request bit is set and its bit in the 13-bit mask (address 8) is clear.
- R7: With configuration bit 7 set, request bits 5 and 6 (which follow `rx_fifo_req` and `tx_fifo_req`) do not raise `irq`, and they drive `dma_rx_req` and `dma_tx_req` instead. With bit 7 clear, both DMA outputs are low.
- R8: The command index (address 10) keeps 6 bits and reads back with bit 6 set. Address 11 holds argument bits [31:16] and address 12 holds bits [15:0]. Each write changes only its own half.
- R9: Write masks are 3 bits for clock rate (address 2), 7 bits for response timeout (4), 16 bits for read timeout (5), 12 bits for block length (6) and 16 bits for block count (7). Reads of address 0 return zero.
- R10: After a successful completion, `xfer_active` stays high only if configuration bit 2 (data enable) is set. After a timeout or a no-data command it is low.
- R11: While `cmd_start` is high, `cmd_index` and `cmd_arg` carry the programmed index and argument.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (advances the response queue) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| cmd_start | output | 1 | One-cycle command issue pulse |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| card_len_vld | input | 1 | Response byte count valid |
| card_len | input | 5 | Response byte count |
| card_byte_vld | input | 1 | Response byte valid |
| card_byte | input | 8 | Response byte |
| xfer_active | output | 1 | Data transfer active |
| rx_fifo_req | input | 1 | Receive FIFO service request |
| tx_fifo_req | input | 1 | Transmit FIFO service request |
| irq | output | 1 | Interrupt line |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
Every register write and every card handshake is captured on a single edge. `cmd_start` and the new status, request and `xfer_active` values all appear one cycle after the edge that accepts the write, the count or the final byte. `irq`, the DMA requests and `reg_rdata` follow their inputs within the same cycle. The bench drives inputs on falling edges and samples on the falling edge after the capturing rising edge. It reads the queue with the data sampled before the rising edge that advances it. It sweeps all response types, byte counts around each minimum and beyond the queue, and both data-enable settings. Expected status, queue contents and activity are computed arithmetically for each case.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;

  localparam int RW     = 16;  // register port width
  localparam int AW     = 4;   // register word address width
  localparam int IRQ_W  = 13;  // request / mask width
  localparam int CFG_W  = 14;
  localparam logic [CFG_W-1:0] CFG_WMASK = 14'h3DFF;

  // configuration bit positions
  localparam int CFG_DEN  = 2;
  localparam int CFG_DMA  = 7;
  localparam int CFG_HOLD = 10;

  // status / request bit positions
  localparam int ST_TOUT  = 1;
  localparam int ST_CLKON = 8;
  localparam int ST_DONE  = 13;
  localparam int RQ_ENDC  = 2;
  localparam int RQ_CLKOFF = 4;
  localparam int RQ_RXF   = 5;
  localparam int RQ_TXF   = 6;

  typedef enum logic [AW-1:0] {
    RA_CLKCTL = 4'd0,
    RA_STAT   = 4'd1,
    RA_CLKDIV = 4'd2,
    RA_CFG    = 4'd3,
    RA_RSPTO  = 4'd4,
    RA_RDTO   = 4'd5,
    RA_BLKLEN = 4'd6,
    RA_BLKCNT = 4'd7,
    RA_IMASK  = 4'd8,
    RA_IREQ   = 4'd9,
    RA_CMDIDX = 4'd10,
    RA_ARGHI  = 4'd11,
    RA_ARGLO  = 4'd12,
    RA_RSPQ   = 4'd13
  } reg_addr_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_LEN   = 2'd1,
    SQ_BYTES = 2'd2
  } seq_state_e;

  // minimum response byte count per response type
  function automatic logic [4:0] rsp_min_len(input logic [1:0] rtype);
    case (rtype)
      2'd0:    rsp_min_len = 5'd0;
      2'd2:    rsp_min_len = 5'd16;
      default: rsp_min_len = 5'd4;
    endcase
  endfunction

endpackage

// File: rtl/cs_rst_sync.sv
module cs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/cs_cfg_regs.sv
module cs_cfg_regs
  import card_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [RW-1:0]     wdata,
  output logic [2:0]        clkdiv,
  output logic [6:0]        rspto,
  output logic [15:0]       rdto,
  output logic [11:0]       blklen,
  output logic [15:0]       blkcnt,
  output logic [CFG_W-1:0]  cfg,
  output logic [IRQ_W-1:0]  imask,
  output logic [5:0]        cmd_idx,
  output logic [31:0]       arg
);
  logic [2:0]       clkdiv_n;
  logic [6:0]       rspto_n;
  logic [15:0]      rdto_n, blkcnt_n;
  logic [11:0]      blklen_n;
  logic [CFG_W-1:0] cfg_n;
  logic [IRQ_W-1:0] imask_n;
  logic [5:0]       cmd_idx_n;
  logic [31:0]      arg_n;

  always_comb begin
    clkdiv_n  = clkdiv;
    rspto_n   = rspto;
    rdto_n    = rdto;
    blklen_n  = blklen;
    blkcnt_n  = blkcnt;
    cfg_n     = cfg;
    imask_n   = imask;
    cmd_idx_n = cmd_idx;
    arg_n     = arg;
    if (we) begin
      case (waddr)
        RA_CLKDIV: clkdiv_n  = wdata[2:0];
        RA_RSPTO:  rspto_n   = wdata[6:0];
        RA_RDTO:   rdto_n    = wdata;
        RA_BLKLEN: blklen_n  = wdata[11:0];
        RA_BLKCNT: blkcnt_n  = wdata;
        RA_CFG:    cfg_n     = wdata[CFG_W-1:0] & CFG_WMASK;
        RA_IMASK:  imask_n   = wdata[IRQ_W-1:0];
        RA_CMDIDX: cmd_idx_n = wdata[5:0];
        RA_ARGHI:  arg_n     = {wdata, arg[15:0]};
        RA_ARGLO:  arg_n     = {arg[31:16], wdata};
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkdiv  <= '0;
      rspto   <= '0;
      rdto    <= '0;
      blklen  <= '0;
      blkcnt  <= '0;
      cfg     <= '0;
      imask   <= '0;
      cmd_idx <= '0;
      arg     <= '0;
    end else if (we) begin
      clkdiv  <= clkdiv_n;
      rspto   <= rspto_n;
      rdto    <= rdto_n;
      blklen  <= blklen_n;
      blkcnt  <= blkcnt_n;
      cfg     <= cfg_n;
      imask   <= imask_n;
      cmd_idx <= cmd_idx_n;
      arg     <= arg_n;
    end
  end
endmodule

// File: rtl/cs_rsp_queue.sv
module cs_rsp_queue #(
  parameter int DEPTH = 9,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,     // command issued: empty and zero
  input  logic             we,
  input  logic [IDX_W-1:0] widx,    // byte index within the response
  input  logic [7:0]       wbyte,
  input  logic             arm,     // valid completion: make readable
  input  logic             pop,
  output logic [15:0]      head
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] EMPTY = PW'(DEPTH);

  logic [15:0]   ent_w [DEPTH];
  logic [PW-1:0] ptr_q, ptr_n;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(g);
    logic [15:0] ent_q, ent_n;
    logic        hit;

    assign hit = we && ((widx >> 1) == SLOT);

    always_comb begin
      ent_n = ent_q;
      if (clr)           ent_n = '0;
      else if (hit) begin
        if (widx[0])     ent_n[15:8] = wbyte;
        else             ent_n[7:0]  = wbyte;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ent_q <= '0;
      else if (clr || hit) ent_q <= ent_n;
    end

    assign ent_w[g] = ent_q;
  end

  always_comb begin
    ptr_n = ptr_q;
    if (clr)                     ptr_n = EMPTY;
    else if (arm)                ptr_n = '0;
    else if (pop && ptr_q < EMPTY) ptr_n = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ptr_q <= EMPTY;
    else if (clr || arm || pop) ptr_q <= ptr_n;
  end

  always_comb begin
    head = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ptr_q == PW'(i)) head = ent_w[i];
    end
  end
endmodule

// File: rtl/cs_irq_route.sv
module cs_irq_route
  import card_seq_pkg::*;
(
  input  logic [IRQ_W-1:0] ireq,
  input  logic [IRQ_W-1:0] imask,
  input  logic             dma_en,
  output logic             irq,
  output logic             dma_rx,
  output logic             dma_tx
);
  logic [IRQ_W-1:0] eff_mask;

  always_comb begin
    eff_mask = imask;
    if (dma_en) begin
      eff_mask[RQ_RXF] = 1'b1;
      eff_mask[RQ_TXF] = 1'b1;
    end
  end

  assign irq    = |(ireq & ~eff_mask);
  assign dma_rx = dma_en & ireq[RQ_RXF];
  assign dma_tx = dma_en & ireq[RQ_TXF];
endmodule

// File: rtl/card_cmd_seq.sv
module card_cmd_seq
  import card_seq_pkg::*;
#(
  parameter int RSP_DEPTH = 9,
  parameter int LEN_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_re,
  input  logic [3:0]       reg_addr,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  output logic             cmd_start,
  output logic [5:0]       cmd_index,
  output logic [31:0]      cmd_arg,
  input  logic             card_len_vld,
  input  logic [LEN_W-1:0] card_len,
  input  logic             card_byte_vld,
  input  logic [7:0]       card_byte,
  output logic             xfer_active,
  input  logic             rx_fifo_req,
  input  logic             tx_fifo_req,
  output logic             irq,
  output logic             dma_rx_req,
  output logic             dma_tx_req
);
  localparam int QBYTES = 2 * RSP_DEPTH;

  logic srst_n;
  cs_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  // configuration registers
  logic [2:0]       clkdiv_q;
  logic [6:0]       rspto_q;
  logic [15:0]      rdto_q, blkcnt_q;
  logic [11:0]      blklen_q;
  logic [CFG_W-1:0] cfg_q;
  logic [IRQ_W-1:0] imask_q;
  logic [5:0]       cmd_idx_q;
  logic [31:0]      arg_q;

  cs_cfg_regs u_regs (
    .clk(clk), .rst_n(srst_n), .we(reg_we), .waddr(reg_addr), .wdata(reg_wdata),
    .clkdiv(clkdiv_q), .rspto(rspto_q), .rdto(rdto_q), .blklen(blklen_q),
    .blkcnt(blkcnt_q), .cfg(cfg_q), .imask(imask_q), .cmd_idx(cmd_idx_q), .arg(arg_q)
  );

  // decoded accesses
  logic wr_cfg, wr_clk, wr_ireq, start_clk, stop_clk, issue, rd_pop;
  assign wr_cfg    = reg_we && (reg_addr == RA_CFG);
  assign wr_clk    = reg_we && (reg_addr == RA_CLKCTL);
  assign wr_ireq   = reg_we && (reg_addr == RA_IREQ);
  assign start_clk = wr_clk && reg_wdata[1] && !reg_wdata[0];
  assign stop_clk  = wr_clk && reg_wdata[0];
  assign rd_pop    = reg_re && (reg_addr == RA_RSPQ);

  // sequencer state
  seq_state_e       st_q, st_n;
  logic [LEN_W-1:0] len_q, len_n, cnt_q, cnt_n, len_eff;
  logic             pend_q, pend_n;
  logic             clkon_q, clkon_n;
  logic             tout_q, tout_n;
  logic             cdone_q, cdone_n;
  logic             endc_q, endc_n;
  logic             clkoff_q, clkoff_n;
  logic             act_q, act_n;
  logic             start_q;
  logic             done, rsp_ok, byte_we, abort;

  assign issue = (wr_cfg && !reg_wdata[CFG_HOLD] && clkon_q)
              || (start_clk && pend_q && !cfg_q[CFG_HOLD]);
  assign abort = stop_clk || wr_cfg;

  always_comb begin
    st_n    = st_q;
    len_n   = len_q;
    cnt_n   = cnt_q;
    done    = 1'b0;
    byte_we = 1'b0;
    case (st_q)
      SQ_LEN: begin
        if (card_len_vld) begin
          if (card_len == '0) begin
            done = 1'b1;
            st_n = SQ_IDLE;
          end else begin
            len_n = card_len;
            cnt_n = '0;
            st_n  = SQ_BYTES;
          end
        end
      end
      SQ_BYTES: begin
        if (card_byte_vld) begin
          byte_we = (cnt_q < LEN_W'(QBYTES));
          cnt_n   = cnt_q + 1'b1;
          if (cnt_q == len_q - 1'b1) begin
            done = 1'b1;
            st_n = SQ_IDLE;
          end
        end
      end
      default: ;
    endcase
    if (abort) begin
      st_n = SQ_IDLE;
      done = 1'b0;
    end
    if (issue) begin
      st_n  = SQ_LEN;
      cnt_n = '0;
    end
  end

  assign len_eff = (st_q == SQ_LEN) ? card_len : len_q;
  assign rsp_ok  = (len_eff >= rsp_min_len(cfg_q[1:0]));

  always_comb begin
    pend_n   = pend_q;
    clkon_n  = clkon_q;
    tout_n   = tout_q;
    cdone_n  = cdone_q;
    endc_n   = endc_q;
    clkoff_n = clkoff_q;
    act_n    = act_q;

    if (wr_ireq && reg_wdata[RQ_ENDC]) endc_n = 1'b0;
    if (wr_cfg) begin
      pend_n = 1'b1;
      act_n  = 1'b0;
      if (!reg_wdata[CFG_HOLD]) begin
        tout_n  = 1'b0;
        cdone_n = 1'b0;
      end
    end
    if (start_clk) begin
      clkon_n  = 1'b1;
      clkoff_n = 1'b0;
    end
    if (stop_clk) begin
      clkon_n  = 1'b0;
      clkoff_n = 1'b1;
      act_n    = 1'b0;
    end
    if (done) begin
      if (rsp_ok) begin
        cdone_n = 1'b1;
        act_n   = cfg_q[CFG_DEN];
      end else begin
        tout_n  = 1'b1;
        act_n   = 1'b0;
      end
    end
    if (issue) begin
      pend_n  = 1'b0;
      act_n   = 1'b1;
      endc_n  = 1'b1;
      tout_n  = 1'b0;
      cdone_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q     <= SQ_IDLE;
      len_q    <= '0;
      cnt_q    <= '0;
      pend_q   <= 1'b0;
      clkon_q  <= 1'b0;
      tout_q   <= 1'b0;
      cdone_q  <= 1'b0;
      endc_q   <= 1'b0;
      clkoff_q <= 1'b0;
      act_q    <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      st_q     <= st_n;
      len_q    <= len_n;
      cnt_q    <= cnt_n;
      pend_q   <= pend_n;
      clkon_q  <= clkon_n;
      tout_q   <= tout_n;
      cdone_q  <= cdone_n;
      endc_q   <= endc_n;
      clkoff_q <= clkoff_n;
      act_q    <= act_n;
      start_q  <= issue;
    end
  end

  // response queue
  logic [15:0] rsp_head;
  cs_rsp_queue #(.DEPTH(RSP_DEPTH), .IDX_W(LEN_W)) u_rspq (
    .clk(clk), .rst_n(srst_n), .clr(issue), .we(byte_we), .widx(cnt_q),
    .wbyte(card_byte), .arm(done && rsp_ok), .pop(rd_pop), .head(rsp_head)
  );

  // interrupt request vector and routing
  logic [IRQ_W-1:0] ireq;
  always_comb begin
    ireq             = '0;
    ireq[RQ_ENDC]    = endc_q;
    ireq[RQ_CLKOFF]  = clkoff_q;
    ireq[RQ_RXF]     = rx_fifo_req;
    ireq[RQ_TXF]     = tx_fifo_req;
  end

  cs_irq_route u_irq (
    .ireq(ireq), .imask(imask_q), .dma_en(cfg_q[CFG_DMA]),
    .irq(irq), .dma_rx(dma_rx_req), .dma_tx(dma_tx_req)
  );

  // read mux
  logic [15:0] stat_w;
  always_comb begin
    stat_w           = '0;
    stat_w[ST_TOUT]  = tout_q;
    stat_w[ST_CLKON] = clkon_q;
    stat_w[ST_DONE]  = cdone_q;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_STAT:   reg_rdata = stat_w;
      RA_CLKDIV: reg_rdata = 16'(clkdiv_q);
      RA_CFG:    reg_rdata = 16'(cfg_q);
      RA_RSPTO:  reg_rdata = 16'(rspto_q);
      RA_RDTO:   reg_rdata = rdto_q;
      RA_BLKLEN: reg_rdata = 16'(blklen_q);
      RA_BLKCNT: reg_rdata = blkcnt_q;
      RA_IMASK:  reg_rdata = 16'(imask_q);
      RA_IREQ:   reg_rdata = 16'(ireq);
      RA_CMDIDX: reg_rdata = {9'd0, 1'b1, cmd_idx_q};
      RA_ARGHI:  reg_rdata = arg_q[31:16];
      RA_ARGLO:  reg_rdata = arg_q[15:0];
      RA_RSPQ:   reg_rdata = rsp_head;
      default:   reg_rdata = '0;
    endcase
  end

  assign cmd_start   = start_q;
  assign cmd_index   = cmd_idx_q;
  assign cmd_arg     = arg_q;
  assign xfer_active = act_q;
endmodule

// File: rtl/card_cmd_seq_chk.sv
module card_cmd_seq_chk
  import card_seq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_start,
  input logic             clkon,
  input logic [IRQ_W-1:0] ireq,
  input logic [IRQ_W-1:0] imask,
  input logic [CFG_W-1:0] cfg,
  input logic             irq,
  input logic             dma_rx_req,
  input logic             dma_tx_req,
  input logic             tout,
  input logic             cdone
);
  // R2
  issue_needs_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> clkon);

  // R4
  issue_sets_endcmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> ireq[RQ_ENDC]);

  // R6
  full_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&imask) |-> !irq);

  // R7
  dma_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg[CFG_DMA] |-> (!dma_rx_req && !dma_tx_req));

  // R3
  single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tout && cdone));

  // R3
  outcome_cleared_on_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> (!tout && !cdone));
endmodule

bind card_cmd_seq card_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .clkon(clkon_q),
  .ireq(ireq), .imask(imask_q), .cfg(cfg_q), .irq(irq),
  .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req),
  .tout(tout_q), .cdone(cdone_q)
);

// File: tb/card_cmd_seq_bench.sv
`timescale 1ns/1ps
module card_cmd_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we, reg_re;
  logic [3:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        cmd_start;
  logic [5:0]  cmd_index;
  logic [31:0] cmd_arg;
  logic        card_len_vld, card_byte_vld;
  logic [4:0]  card_len;
  logic [7:0]  card_byte;
  logic        xfer_active, rx_fifo_req, tx_fifo_req, irq, dma_rx_req, dma_tx_req;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  card_cmd_seq u_card_cmd_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_start(cmd_start),
    .cmd_index(cmd_index), .cmd_arg(cmd_arg), .card_len_vld(card_len_vld),
    .card_len(card_len), .card_byte_vld(card_byte_vld), .card_byte(card_byte),
    .xfer_active(xfer_active), .rx_fifo_req(rx_fifo_req), .tx_fifo_req(tx_fifo_req),
    .irq(irq), .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, 32'(v), 32'(exp));
  endtask

  function automatic logic [7:0] rbyte(input int seed, input int i);
    return 8'((seed * 7 + i * 13 + 1) & 255);
  endfunction

  // answer a command with len bytes; returns at the negedge after the last capture
  task automatic card_answer(input int len, input int seed);
    card_len_vld = 1'b1; card_len = 5'(len);
    @(negedge clk);
    card_len_vld = 1'b0;
    for (int i = 0; i < len; i++) begin
      card_byte_vld = 1'b1; card_byte = rbyte(seed, i);
      @(negedge clk);
    end
    card_byte_vld = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int lens [7] = '{0, 2, 3, 4, 15, 16, 20};
    rst_n = 1'b0; reg_we = 0; reg_re = 0; reg_addr = 0; reg_wdata = 0;
    card_len_vld = 0; card_len = 0; card_byte_vld = 0; card_byte = 0;
    rx_fifo_req = 0; tx_fifo_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    rd_chk("R3 reset status", 4'd1, 16'h0000);
    rd_chk("R4 reset requests", 4'd9, 16'h0000);
    chk("R6 reset irq", 32'(irq), 0);
    rd_chk("R8 reset index", 4'd10, 16'h0040);
    rd_chk("R5 reset queue", 4'd13, 16'h0000);
    chk("R10 reset active", 32'(xfer_active), 0);

    // write masks
    wr(4'd2, 16'hFFFF);  rd_chk("R9 clock rate", 4'd2, 16'h0007);
    wr(4'd4, 16'hFFFF);  rd_chk("R9 rsp timeout", 4'd4, 16'h007F);
    wr(4'd5, 16'hFFFF);  rd_chk("R9 read timeout", 4'd5, 16'hFFFF);
    wr(4'd6, 16'hFFFF);  rd_chk("R9 block len", 4'd6, 16'h0FFF);
    wr(4'd7, 16'hFFFF);  rd_chk("R9 block count", 4'd7, 16'hFFFF);
    wr(4'd8, 16'hFFFF);  rd_chk("R6 mask width", 4'd8, 16'h1FFF);
    wr(4'd10, 16'hFFFF); rd_chk("R8 index width", 4'd10, 16'h007F);
    rd_chk("R9 clkctl reads zero", 4'd0, 16'h0000);
    wr(4'd3, 16'hFFFF);
    chk("R1 hold blocks issue", 32'(cmd_start), 0);
    rd_chk("R1 config mask", 4'd3, 16'h3DFF);
    wr(4'd8, 16'h0000);

    // clock start with hold set: no issue
    wr(4'd0, 16'h0002);
    chk("R2 hold blocks start issue", 32'(cmd_start), 0);
    rd_chk("R2 clock on status", 4'd1, 16'h0100);
    wr(4'd0, 16'h0001);
    rd_chk("R2 clock off status", 4'd1, 16'h0000);
    rd_chk("R2 clock off request", 4'd9, 16'h0010);
    chk("R6 clock off irq", 32'(irq), 1);

    // pending command waits for the clock
    wr(4'd10, 16'h0011); wr(4'd11, 16'hCAFE); wr(4'd12, 16'hF00D);
    wr(4'd3, 16'h0001);
    chk("R1 clock off blocks issue", 32'(cmd_start), 0);
    repeat (3) @(negedge clk);
    chk("R1 still waiting", 32'(cmd_start), 0);
    wr(4'd0, 16'h0002);
    chk("R2 start issues pending", 32'(cmd_start), 1);
    chk("R11 index", 32'(cmd_index), 32'h11);
    chk("R11 argument", cmd_arg, 32'hCAFEF00D);
    card_answer(4, 0);
    rd_chk("R4 request after issue", 4'd9, 16'h0004);

    // mask sweep with only request bit 2 set
    for (int b = 0; b < 13; b++) begin
      wr(4'd8, 16'(1 << b));
      #1 chk("R6 mask sweep", 32'(irq), (b == 2) ? 0 : 1);
    end
    wr(4'd8, 16'h0000);
    wr(4'd9, 16'h0004);
    rd_chk("R4 clear end request", 4'd9, 16'h0000);
    chk("R6 no request no irq", 32'(irq), 0);

    // DMA routing (hold bit set so no issue)
    for (int m = 0; m < 4; m++) begin
      rx_fifo_req = m[0]; tx_fifo_req = m[1];
      wr(4'd3, 16'h0400);
      #1;
      chk("R6 fifo requests raise irq", 32'(irq), (m != 0) ? 1 : 0);
      chk("R7 dma off rx", 32'(dma_rx_req), 0);
      chk("R7 dma off tx", 32'(dma_tx_req), 0);
      wr(4'd3, 16'h0480);
      #1;
      chk("R7 dma on masks irq", 32'(irq), 0);
      chk("R7 dma rx", 32'(dma_rx_req), 32'(m[0]));
      chk("R7 dma tx", 32'(dma_tx_req), 32'(m[1]));
    end
    rx_fifo_req = 0; tx_fifo_req = 0;

    // argument halves
    wr(4'd11, 16'hABCD); wr(4'd12, 16'h1234);
    rd_chk("R8 arg high", 4'd11, 16'hABCD);
    rd_chk("R8 arg low", 4'd12, 16'h1234);
    wr(4'd11, 16'h5555);
    rd_chk("R8 low kept", 4'd12, 16'h1234);
    rd_chk("R8 high updated", 4'd11, 16'h5555);

    // response sweep
    for (int ty = 0; ty < 4; ty++) begin
      for (int li = 0; li < 7; li++) begin
        for (int de = 0; de < 2; de++) begin
          int L, seed, mn;
          bit ok;
          L = lens[li];
          seed = ty * 16 + li * 2 + de;
          mn = (ty == 0) ? 0 : (ty == 2) ? 16 : 4;
          ok = (L >= mn);
          wr(4'd10, 16'(seed & 63));
          wr(4'd11, 16'(seed * 257));
          wr(4'd12, 16'(seed * 4099));
          wr(4'd3, 16'(ty | (de << 2)));
          chk("R1 issue after config", 32'(cmd_start), 1);
          chk("R11 sweep index", 32'(cmd_index), 32'(seed & 63));
          chk("R11 sweep arg", cmd_arg, {16'(seed * 257), 16'(seed * 4099)});
          chk("R3 status cleared at issue", 32'(cmd_start && 1'b1), 1);
          card_answer(L, seed);
          chk("R10 active", 32'(xfer_active), 32'(de == 1 && ok));
          rd_chk("R3 outcome", 4'd1, ok ? 16'h2100 : 16'h0102);
          rd_chk("R4 end request", 4'd9, 16'h0004);
          for (int k = 0; k < 10; k++) begin
            logic [15:0] e;
            e = 16'h0;
            if (ok && k < 9) begin
              if (2 * k < L)     e[7:0]  = rbyte(seed, 2 * k);
              if (2 * k + 1 < L) e[15:8] = rbyte(seed, 2 * k + 1);
            end
            rd_chk("R5 queue entry", 4'd13, e);
          end
          wr(4'd9, 16'h0004);
        end
      end
    end

    // clock stop aborts an active transfer and a pending wait
    wr(4'd3, 16'h0005);
    card_answer(4, 3);
    chk("R10 data command active", 32'(xfer_active), 1);
    wr(4'd0, 16'h0001);
    chk("R2 stop clears active", 32'(xfer_active), 0);
    wr(4'd0, 16'h0002);
    chk("R2 restart no reissue", 32'(cmd_start), 0);
    wr(4'd3, 16'h0001);
    chk("R1 reissue", 32'(cmd_start), 1);
    wr(4'd0, 16'h0001);
    card_answer(4, 5);
    rd_chk("R2 abandoned wait", 4'd1, 16'h0000);
    rd_chk("R5 abandoned queue", 4'd13, 16'h0000);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule